// File: doc/BRIEF.md
# Charge-Split Tap Gate Sequencer

This block drives the digital gate timing for an array of pixels that each hold one photodiode and four storage taps. It produces a high-dynamic-range capture from a single exposure. Charge is split between the taps. Within one frame the exposure is a short sub-cycle repeated N times. In each sub-cycle, the transfer-gate enables for four sensitivity ranks take turns, each for its own programmed number of clocks. A tap's total exposure is therefore its per-sub-cycle width times N. Ranks can be assigned to any physical tap. After exposure the block runs a readout sequence, then a floating-diffusion reset, and then reports that the frame is complete.

Software places the per-rank widths, the rank-to-tap assignment, the repeat count and the mode on the inputs, then pulses `frame_start`. The block copies the whole configuration on that pulse and runs the frame on its own. A second mode injects charge: all four transfer gates stay open together with the drain for a programmed interval, and readout and reset then follow as usual.

Top module: `tapsplit_seq`

## Requirements
- R1: During exposure at most one of `tg_en[3:0]` is high in any cycle, and `drain_en` is low in every exposure cycle.
- R2: Exposure begins two rising edges after `frame_start` is sampled in idle. The first of those edges copies the configuration. Exposure runs the sub-cycle `max(N,1)` times, where N is `repeat_n`. Each sub-cycle visits ranks 0,1,2,3 in that order, and rank r holds `tg_en` bit `map[r]` high for its effective width. `on_time` bits [16r+15:16r] give rank r's width. `tap_map` bits [2r+1:2r] give rank r's physical tap index, 0..3.
- R3: A nonzero width below MIN_ON (2 clocks) is stretched to MIN_ON. Larger widths are used unchanged.
- R4: A rank whose width is zero gets no window at all. If all four widths are zero, exposure takes no cycles and readout starts in the cycle where exposure would have started.
- R5: With `use_default` high, the widths 1000,100,10,1 and the tap order 0,1,3,2 replace the inputs. This is a 10x step between ranks, with rank 3 on tap index 2.
- R6: Readout lasts 8*RD_CYC cycles. `drain_en` is high and all `tg_en` are low throughout. It takes eight samples of RD_CYC cycles each, for taps 0,1,2,3 in turn. Each tap gets a signal sample and then a reset sample. `rd_sig_stb` or `rd_rst_stb` is high only in the first cycle of its sample, and `rd_tap` names the tap.
- R7: `fdrst_en` is high for RST_CYC (3) cycles, starting in the cycle right after readout. `frame_done` is then high for exactly one cycle, and the block returns to idle.
- R8: With `test_inject` high, all four `tg_en` and `drain_en` are high for `inject_len` cycles, or for 1 cycle if `inject_len` is 0. Readout and reset then follow exactly as in R6 and R7.
- R9: A `frame_start` while a frame is running has no effect. Changes to the configuration inputs during a frame have no effect on that frame.
- R10: After reset and while idle, `drain_en` is high and all other outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a frame when idle |
| test_inject | input | 1 | Selects charge-injection mode |
| use_default | input | 1 | Selects built-in widths and tap order |
| on_time | input | 4*W_ON | Per-rank window width in clocks |
| tap_map | input | 8 | Physical tap index per rank |
| repeat_n | input | W_REP | Sub-cycle repeat count |
| inject_len | input | W_ON | Injection interval in clocks |
| tg_en | output | 4 | Transfer-gate enables, one bit per physical tap |
| drain_en | output | 1 | Drain-gate enable |
| fdrst_en | output | 1 | Floating-diffusion reset enable |
| rd_sig_stb | output | 1 | Signal-level sample strobe |
| rd_rst_stb | output | 1 | Reset-level sample strobe |
| rd_tap | output | 2 | Tap being sampled |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench predicts the expected gate for every exposure cycle from the sub-cycle position. A slot walker that wraps wrongly or loses the repeat count would show up as a shifted or truncated pattern. Widths of one are checked against MIN_ON stretching, a missed clamp would yield single-cycle windows. The bench also covers a single nonzero rank, which gives a continuous window with no wrap glitch, and an all-zero configuration, where a design without the skip would hang or emit empty windows. N of zero, N of 800 and a reversed tap order exercise counting and mapping. A frame-start pulse with altered widths in mid-exposure catches a design that restarts or relatches.

// File: rtl/tapseq_pkg.sv
package tapseq_pkg;
  localparam int NSLOT = 4;

  typedef logic [1:0] tap_idx_t;

  typedef struct packed {
    logic     wrap;
    tap_idx_t idx;
  } slot_step_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_EXPO,
    PH_INJ,
    PH_POST
  } phase_t;

  function automatic logic [NSLOT-1:0] tap_onehot(input tap_idx_t t);
    return NSLOT'(1) << t;
  endfunction

  // next enabled slot after cur, searching forward with wrap-around
  function automatic slot_step_t next_slot(input logic [NSLOT-1:0] mask,
                                           input tap_idx_t cur);
    slot_step_t r;
    logic [2:0] s;
    r.wrap = 1'b1;
    r.idx  = cur;
    for (int d = NSLOT; d >= 1; d--) begin
      s = {1'b0, cur} + 3'(d);
      if (mask[s[1:0]]) begin
        r.idx  = s[1:0];
        r.wrap = s[2];
      end
    end
    return r;
  endfunction

  function automatic int def_width(input int rank);
    case (rank)
      0: return 1000;
      1: return 100;
      2: return 10;
      default: return 1;
    endcase
  endfunction

  function automatic tap_idx_t def_tap(input int rank);
    case (rank)
      0: return 2'd0;
      1: return 2'd1;
      2: return 2'd3;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/tapseq_cfg_latch.sv
module tapseq_cfg_latch
  import tapseq_pkg::*;
#(
  parameter int W_ON   = 16,
  parameter int W_REP  = 10,
  parameter int MIN_ON = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic                         use_default,
  input  logic                         test_inject,
  input  logic [NSLOT*W_ON-1:0]        on_time,
  input  logic [2*NSLOT-1:0]           tap_map,
  input  logic [W_REP-1:0]             repeat_n,
  input  logic [W_ON-1:0]              inject_len,
  output logic [NSLOT-1:0][W_ON-1:0]   eff,
  output tap_idx_t [NSLOT-1:0]         map,
  output logic [NSLOT-1:0]             mask,
  output logic [W_REP-1:0]             n_last,
  output logic                         inj,
  output logic [W_ON-1:0]              inj_len
);
  localparam logic [W_ON-1:0] MIN_W = W_ON'(MIN_ON);

  logic [NSLOT-1:0][W_ON-1:0] eff_d;
  tap_idx_t [NSLOT-1:0]       map_d;

  for (genvar r = 0; r < NSLOT; r++) begin : g_slot
    logic [W_ON-1:0] raw;
    always_comb begin
      raw      = use_default ? W_ON'(def_width(r)) : on_time[r*W_ON +: W_ON];
      map_d[r] = use_default ? def_tap(r) : tap_map[2*r +: 2];
      if (raw == '0)        eff_d[r] = '0;
      else if (raw < MIN_W) eff_d[r] = MIN_W;
      else                  eff_d[r] = raw;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        eff[r]  <= '0;
        map[r]  <= '0;
        mask[r] <= 1'b0;
      end else if (load) begin
        eff[r]  <= eff_d[r];
        map[r]  <= map_d[r];
        mask[r] <= (eff_d[r] != '0);
      end
    end

    // R3
    clamp_floor_chk: assert property (@(posedge clk) disable iff (rst)
      mask[r] |-> (eff[r] >= MIN_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_last  <= '0;
      inj     <= 1'b0;
      inj_len <= '0;
    end else if (load) begin
      n_last  <= (repeat_n == '0) ? '0 : repeat_n - W_REP'(1);
      inj     <= test_inject;
      inj_len <= (inject_len == '0) ? W_ON'(1) : inject_len;
    end
  end
endmodule

// File: rtl/tapseq_expo_engine.sv
module tapseq_expo_engine
  import tapseq_pkg::*;
#(
  parameter int W_ON   = 16,
  parameter int W_REP  = 10,
  parameter int MIN_ON = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       go,
  input  logic [NSLOT-1:0][W_ON-1:0] eff,
  input  tap_idx_t [NSLOT-1:0]       map,
  input  logic [NSLOT-1:0]           mask,
  input  logic [W_REP-1:0]           n_last,
  output logic [NSLOT-1:0]           tg,
  output logic                       active,
  output logic                       last
);
  tap_idx_t        slot;
  logic [W_ON-1:0] cnt;
  logic [W_REP-1:0] rep;
  slot_step_t      step, start;

  always_comb begin
    step  = next_slot(mask, slot);
    start = next_slot(mask, tap_idx_t'(NSLOT-1));
    last  = active && (cnt == W_ON'(1)) && step.wrap && (rep == n_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= '0;
      cnt    <= '0;
      rep    <= '0;
      active <= 1'b0;
      tg     <= '0;
    end else if (go) begin
      slot   <= start.idx;
      cnt    <= eff[start.idx];
      rep    <= '0;
      active <= 1'b1;
      tg     <= tap_onehot(map[start.idx]);
    end else if (active) begin
      if (cnt == W_ON'(1)) begin
        if (last) begin
          active <= 1'b0;
          tg     <= '0;
        end else begin
          slot <= step.idx;
          cnt  <= eff[step.idx];
          tg   <= tap_onehot(map[step.idx]);
          if (step.wrap) rep <= rep + W_REP'(1);
        end
      end else begin
        cnt <= cnt - W_ON'(1);
      end
    end
  end

  // R1
  engine_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> $onehot(tg));
  // R3
  window_min_chk: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == W_ON'(1) && !last) |=> (cnt >= W_ON'(MIN_ON)));
  // R2
  rep_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (rep <= n_last));
endmodule

// File: rtl/tapseq_post_unit.sv
module tapseq_post_unit #(
  parameter int RD_CYC  = 2,
  parameter int RST_CYC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  output logic       sig_stb,
  output logic       rst_stb,
  output logic [1:0] tap,
  output logic       fdrst,
  output logic       done,
  output logic       fin
);
  localparam int W_RD = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;
  localparam int W_RS = $clog2(RST_CYC + 1);
  localparam logic [W_RD-1:0] RD_END = W_RD'(RD_CYC - 1);

  logic            rd_act, rs_act, rd_last;
  logic [2:0]      k;
  logic [W_RD-1:0] c;
  logic [W_RS-1:0] rs_cnt;

  assign rd_last = rd_act && (k == 3'd7) && (c == RD_END);
  assign fin     = rs_act && (rs_cnt == W_RS'(1));
  assign tap     = k[2:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act  <= 1'b0;
      k       <= '0;
      c       <= '0;
      sig_stb <= 1'b0;
      rst_stb <= 1'b0;
    end else if (go) begin
      rd_act  <= 1'b1;
      k       <= '0;
      c       <= '0;
      sig_stb <= 1'b1;
      rst_stb <= 1'b0;
    end else if (rd_act) begin
      if (c == RD_END) begin
        c <= '0;
        if (k == 3'd7) begin
          rd_act  <= 1'b0;
          sig_stb <= 1'b0;
          rst_stb <= 1'b0;
        end else begin
          k       <= k + 3'd1;
          sig_stb <= k[0];
          rst_stb <= ~k[0];
        end
      end else begin
        c       <= c + W_RD'(1);
        sig_stb <= 1'b0;
        rst_stb <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_act <= 1'b0;
      rs_cnt <= '0;
      fdrst  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= fin;
      if (rd_last) begin
        rs_act <= 1'b1;
        rs_cnt <= W_RS'(RST_CYC);
        fdrst  <= 1'b1;
      end else if (rs_act) begin
        if (rs_cnt == W_RS'(1)) begin
          rs_act <= 1'b0;
          fdrst  <= 1'b0;
        end else begin
          rs_cnt <= rs_cnt - W_RS'(1);
        end
      end
    end
  end

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sig_stb && rst_stb));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  fdrst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fdrst |-> !(sig_stb || rst_stb));
endmodule

// File: rtl/tapsplit_seq.sv
module tapsplit_seq
  import tapseq_pkg::*;
#(
  parameter int W_ON    = 16,
  parameter int W_REP   = 10,
  parameter int MIN_ON  = 2,
  parameter int RD_CYC  = 2,
  parameter int RST_CYC = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_start,
  input  logic                  test_inject,
  input  logic                  use_default,
  input  logic [4*W_ON-1:0]     on_time,
  input  logic [7:0]            tap_map,
  input  logic [W_REP-1:0]      repeat_n,
  input  logic [W_ON-1:0]       inject_len,
  output logic [3:0]            tg_en,
  output logic                  drain_en,
  output logic                  fdrst_en,
  output logic                  rd_sig_stb,
  output logic                  rd_rst_stb,
  output logic [1:0]            rd_tap,
  output logic                  frame_done
);
  phase_t phase;

  logic [NSLOT-1:0][W_ON-1:0] eff;
  tap_idx_t [NSLOT-1:0]       map;
  logic [NSLOT-1:0]           mask;
  logic [W_REP-1:0]           n_last;
  logic                       inj;
  logic [W_ON-1:0]            inj_len, inj_cnt;
  logic [NSLOT-1:0]           eng_tg, inj_tg;
  logic                       eng_act, eng_last, inj_last, post_fin;
  logic                       accept, eng_go, post_go;

  assign accept   = (phase == PH_IDLE) && frame_start;
  assign eng_go   = (phase == PH_SETUP) && !inj && (mask != '0);
  assign inj_last = (phase == PH_INJ) && (inj_cnt == W_ON'(1));
  assign post_go  = ((phase == PH_SETUP) && !inj && (mask == '0))
                  || eng_last || inj_last;

  tapseq_cfg_latch #(.W_ON(W_ON), .W_REP(W_REP), .MIN_ON(MIN_ON)) u_cfg (
    .clk(clk), .rst(rst), .load(accept),
    .use_default(use_default), .test_inject(test_inject),
    .on_time(on_time), .tap_map(tap_map), .repeat_n(repeat_n),
    .inject_len(inject_len),
    .eff(eff), .map(map), .mask(mask), .n_last(n_last),
    .inj(inj), .inj_len(inj_len)
  );

  tapseq_expo_engine #(.W_ON(W_ON), .W_REP(W_REP), .MIN_ON(MIN_ON)) u_eng (
    .clk(clk), .rst(rst), .go(eng_go),
    .eff(eff), .map(map), .mask(mask), .n_last(n_last),
    .tg(eng_tg), .active(eng_act), .last(eng_last)
  );

  tapseq_post_unit #(.RD_CYC(RD_CYC), .RST_CYC(RST_CYC)) u_post (
    .clk(clk), .rst(rst), .go(post_go),
    .sig_stb(rd_sig_stb), .rst_stb(rd_rst_stb), .tap(rd_tap),
    .fdrst(fdrst_en), .done(frame_done), .fin(post_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      drain_en <= 1'b1;
      inj_tg   <= '0;
      inj_cnt  <= '0;
    end else begin
      case (phase)
        PH_IDLE:  if (frame_start) phase <= PH_SETUP;
        PH_SETUP: begin
          if (inj) begin
            phase   <= PH_INJ;
            inj_tg  <= '1;
            inj_cnt <= inj_len;
          end else if (mask == '0) begin
            phase <= PH_POST;
          end else begin
            phase    <= PH_EXPO;
            drain_en <= 1'b0;
          end
        end
        PH_EXPO: if (eng_last) begin
          phase    <= PH_POST;
          drain_en <= 1'b1;
        end
        PH_INJ: begin
          if (inj_last) begin
            phase  <= PH_POST;
            inj_tg <= '0;
          end else begin
            inj_cnt <= inj_cnt - W_ON'(1);
          end
        end
        PH_POST: if (post_fin) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign tg_en = eng_tg | inj_tg;

  // R1
  drain_expo_chk: assert property (@(posedge clk) disable iff (rst)
    ((tg_en != 4'h0) && (tg_en != 4'hF)) |-> !drain_en);
  // R1
  tg_single_chk: assert property (@(posedge clk) disable iff (rst)
    (tg_en != 4'hF) |-> $onehot0(tg_en));
  // R8
  inject_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (tg_en == 4'hF) |-> drain_en);
  // R6
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sig_stb || rd_rst_stb) |-> (drain_en && tg_en == 4'h0));
  // R2
  expo_src_chk: assert property (@(posedge clk) disable iff (rst)
    eng_act |-> (inj_tg == '0));
endmodule

// File: tb/tapsplit_seq_tb_top.sv
`timescale 1ns/1ps
module tapsplit_seq_tb_top;
  localparam int W_ON = 16, W_REP = 10, MIN_ON = 2, RD_CYC = 2, RST_CYC = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic frame_start = 1'b0, test_inject = 1'b0, use_default = 1'b0;
  logic [4*W_ON-1:0] on_time = '0;
  logic [7:0] tap_map = '0;
  logic [W_REP-1:0] repeat_n = '0;
  logic [W_ON-1:0] inject_len = '0;
  logic [3:0] tg_en;
  logic drain_en, fdrst_en, rd_sig_stb, rd_rst_stb, frame_done;
  logic [1:0] rd_tap;

  int total = 0, bad = 0;
  int c_on[4];
  int c_map[4];

  always #2 clk = ~clk;

  tapsplit_seq #(.W_ON(W_ON), .W_REP(W_REP), .MIN_ON(MIN_ON),
                 .RD_CYC(RD_CYC), .RST_CYC(RST_CYC)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .test_inject(test_inject),
    .use_default(use_default), .on_time(on_time), .tap_map(tap_map),
    .repeat_n(repeat_n), .inject_len(inject_len), .tg_en(tg_en),
    .drain_en(drain_en), .fdrst_en(fdrst_en), .rd_sig_stb(rd_sig_stb),
    .rd_rst_stb(rd_rst_stb), .rd_tap(rd_tap), .frame_done(frame_done));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int o0, input int o1, input int o2, input int o3,
                         input int m0, input int m1, input int m2, input int m3);
    c_on[0] = o0; c_on[1] = o1; c_on[2] = o2; c_on[3] = o3;
    c_map[0] = m0; c_map[1] = m1; c_map[2] = m2; c_map[3] = m3;
    for (int r = 0; r < 4; r++) begin
      on_time[r*W_ON +: W_ON] = W_ON'(c_on[r]);
      tap_map[2*r +: 2] = 2'(c_map[r]);
    end
  endtask

  task automatic run_frame(input int n, input bit dflt, input bit inj,
                           input int ilen, input bit poke);
    int e[4];
    int m[4];
    int s, nn, len, j, r, exp_tg, acc;
    logic [4*W_ON-1:0] saved_on;
    saved_on = on_time;
    for (int q = 0; q < 4; q++) begin
      int w;
      w    = dflt ? (q == 0 ? 1000 : q == 1 ? 100 : q == 2 ? 10 : 1) : c_on[q];
      m[q] = dflt ? (q == 0 ? 0 : q == 1 ? 1 : q == 2 ? 3 : 2) : c_map[q];
      e[q] = (w == 0) ? 0 : (w < MIN_ON ? MIN_ON : w);  // R3 R4
    end
    s = e[0] + e[1] + e[2] + e[3];
    nn = (n == 0) ? 1 : n;
    len = inj ? ((ilen == 0) ? 1 : ilen) : nn * s;
    repeat_n = W_REP'(n); use_default = dflt; test_inject = inj;
    inject_len = W_ON'(ilen);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    // setup cycle: still idle-looking (R2)
    chk(tg_en == 0 && drain_en, "R2", "setup tg", int'(tg_en), 0);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (inj) begin
        // R8
        chk(tg_en == 4'hF && drain_en, "R8", "inject gates", int'(tg_en), 15);
      end else begin
        j = i % s; acc = 0; exp_tg = 0;
        for (r = 0; r < 4; r++) begin
          if (exp_tg == 0 && j < acc + e[r]) exp_tg = 1 << m[r];
          acc += e[r];
        end
        // R2 R5 window sequence
        chk(int'(tg_en) == exp_tg, "R2", "expo tg", int'(tg_en), exp_tg);
        // R1
        chk(!drain_en && $countones(tg_en) == 1, "R1", "expo drain/onehot",
            int'(drain_en), 0);
      end
      if (poke && i == 1) begin
        frame_start = 1'b1; on_time = ~on_time;  // R9 stimulus
      end
      if (poke && i == 2) frame_start = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < 8 * RD_CYC; k++) begin
      int smp;
      bit first;
      smp = k / RD_CYC; first = (k % RD_CYC) == 0;
      // R6
      chk(drain_en && tg_en == 0 && !fdrst_en, "R6", "read gates",
          int'(tg_en), 0);
      chk(rd_sig_stb == (first && smp % 2 == 0), "R6", "sig strobe",
          int'(rd_sig_stb), int'(first && smp % 2 == 0));
      chk(rd_rst_stb == (first && smp % 2 == 1), "R6", "rst strobe",
          int'(rd_rst_stb), int'(first && smp % 2 == 1));
      if (first) chk(int'(rd_tap) == smp / 2, "R6", "rd_tap", int'(rd_tap), smp / 2);
      @(negedge clk);
    end
    for (int k = 0; k < RST_CYC; k++) begin
      // R7
      chk(fdrst_en && drain_en && tg_en == 0 && !frame_done && !rd_sig_stb,
          "R7", "fd reset", int'(fdrst_en), 1);
      @(negedge clk);
    end
    chk(frame_done && !fdrst_en, "R7", "done pulse", int'(frame_done), 1);
    @(negedge clk);
    // R10
    chk(!frame_done && drain_en && tg_en == 0 && !fdrst_en, "R10", "back idle",
        int'(frame_done), 0);
    on_time = saved_on;
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(drain_en && tg_en == 0 && !fdrst_en && !rd_sig_stb && !rd_rst_stb
        && !frame_done, "R10", "reset state", int'(tg_en), 0);
    // R5 defaults, 10x ratio, rank 3 on tap index 2
    set_cfg(7, 7, 7, 7, 3, 3, 3, 3);
    run_frame(1, 1'b1, 1'b0, 0, 1'b0);
    // R2 R3 R4 mixed widths
    set_cfg(8, 4, 1, 0, 0, 1, 3, 2);
    run_frame(3, 1'b0, 1'b0, 0, 1'b0);
    // R3 R5 all at the floor, reversed map
    set_cfg(1, 1, 1, 1, 3, 2, 1, 0);
    run_frame(2, 1'b0, 1'b0, 0, 1'b0);
    // R4 single rank, continuous window
    set_cfg(0, 0, 5, 0, 0, 1, 2, 3);
    run_frame(4, 1'b0, 1'b0, 0, 1'b0);
    // R4 all zero: straight to readout
    set_cfg(0, 0, 0, 0, 0, 1, 2, 3);
    run_frame(3, 1'b0, 1'b0, 0, 1'b0);
    // R2 N of zero runs once
    set_cfg(3, 0, 2, 0, 2, 0, 1, 3);
    run_frame(0, 1'b0, 1'b0, 0, 1'b0);
    // R9 frame_start and width change mid-frame
    set_cfg(4, 3, 2, 5, 1, 0, 3, 2);
    run_frame(3, 1'b0, 1'b0, 0, 1'b1);
    // R2 large repeat count
    set_cfg(0, 1, 0, 2, 0, 1, 2, 3);
    run_frame(800, 1'b0, 1'b0, 0, 1'b0);
    // R8 injection
    run_frame(1, 1'b0, 1'b1, 5, 1'b0);
    run_frame(1, 1'b0, 1'b1, 0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule